// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Sequencer

This block controls the nonvolatile side of a battery-free SRAM. It watches two digital supply comparators and a hardware store request. On power-up it copies the nonvolatile array into the SRAM. On power-down it copies the SRAM back into the array, but only if the SRAM has been written since the last such transfer. The array itself is outside the block. It sees only a one-cycle start pulse for each transfer, and each transfer takes a fixed number of clock cycles.

Host read and write strobes pass through a gate. The gate drops them while a transfer runs and while the supply is low. When a store is triggered, writes stay open for a short grace window so that a write already under way can finish. The busy handshake pin has two enables. One pulls the pin low during a transfer. The other drives it high for a short while after the transfer. When the supply falls below a second, lower threshold, both enables are released and the pin floats to its weak pull-up.

All durations are parameters counted in clock cycles. The host must hold `pin_store_n` low for at least one clock edge.

Top module: `nvsram_cycle_ctrl`

## Requirements
- R1: One cycle after `vcc_ok` is first seen high, the block pulses `recall_go` for one cycle. `busy` then stays high for exactly RECALL_CYC cycles, with `rw_block` high for the whole time. After that, `busy` and `rw_block` are both low.
- R2: When `vcc_ok` falls while idle and the SRAM is dirty, `busy` rises on the next cycle. `store_go` pulses GRACE_CYC cycles after that. `busy` stays high for GRACE_CYC+STORE_CYC cycles in total. The block then stays in the powered-down state, with `rw_block` high and `busy` low.
- R3: If no host write has been accepted since the last store or recall, a falling `vcc_ok` or a low `pin_store_n` starts no store. `store_go` and `busy` stay low.
- R4: During the GRACE_CYC cycles after a store trigger, host writes are still accepted.
- R5: `sram_rd` and `sram_wr` repeat `host_rd` and `host_wr` one cycle later. They do so only while the block is idle with `vcc_ok` high, or during the grace window. During a store, during a recall and while the supply is low, the strobes are dropped.
- R6: `hs_drive_lo` is high one cycle after a transfer becomes active and stays high for as long as `busy` is high. When `busy` falls, `hs_drive_hi` is high for HIGH_CYC cycles and then goes low. The two enables are never high together.
- R7: A low `pin_store_n` sampled while idle, powered and dirty starts a store with the same timing as R2. When that store ends, the block returns to idle with `rw_block` low.
- R8: After an automatic store caused by a supply dip, a new rise of `vcc_ok` starts a full recall, as in R1.
- R9: If `vcc_ok` falls during a recall, the recall is abandoned on the next cycle. `busy` goes low, `rw_block` stays high and no store is started.
- R10: While `vcc_live` is low, both handshake enables are low one cycle later, even while `busy` is high.
- R11: Completing a store or a recall marks the SRAM clean. A hardware request made right after a store, with no write in between, starts nothing.
- R12: A hardware request made while a transfer is running has no effect. The transfer length is unchanged and no further store follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vcc_ok | input | 1 | Supply above the switch threshold |
| vcc_live | input | 1 | Supply above the handshake disable threshold |
| pin_store_n | input | 1 | Hardware store request, active low |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| sram_rd | output | 1 | Gated read strobe to the SRAM |
| sram_wr | output | 1 | Gated write strobe to the SRAM |
| busy | output | 1 | Store, grace or recall in progress |
| rw_block | output | 1 | Host access is being ignored |
| store_go | output | 1 | One-cycle start pulse for a store to the array |
| recall_go | output | 1 | One-cycle start pulse for a recall from the array |
| hs_drive_lo | output | 1 | Enable to pull the handshake pin low |
| hs_drive_hi | output | 1 | Enable to drive the handshake pin high |

## Verification
A wrong state in the sequencer is visible at the ports within one cycle as `busy` or `rw_block` in the wrong level. A transfer timer that is off by one shows up only at the end of the transfer, so the bench samples the exact last cycle and the exact first cycle after it. A stuck or missed dirty flag is hidden until the next store trigger. There it appears as a `store_go` that should not be there, or one that is missing. For that reason, every clean and dirty case is followed by a trigger. Handshake window errors appear within HIGH_CYC cycles after `busy` falls.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_RECALL = 3'd1,
    ST_IDLE   = 3'd2,
    ST_GRACE  = 3'd3,
    ST_STORE  = 3'd4
  } nvs_state_t;
endpackage

// File: rtl/nvs_fsm.sv
module nvs_fsm
  import nvs_pkg::*;
#(
  parameter int RECALL_CYC = 40,
  parameter int STORE_CYC  = 24,
  parameter int GRACE_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_ok,
  input  logic       store_req,
  input  logic       dirty,
  output nvs_state_t state_q,
  output nvs_state_t state_nx,
  output logic       store_done,
  output logic       recall_done
);
  localparam int MAXC0 = (RECALL_CYC > STORE_CYC) ? RECALL_CYC : STORE_CYC;
  localparam int MAXC  = (MAXC0 > GRACE_CYC) ? MAXC0 : GRACE_CYC;
  localparam int TW    = $clog2(MAXC + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] ld_val;
  logic          ld;
  logic          cnt_zero;
  logic          fell_q;

  assign cnt_zero    = (cnt_q == '0);
  assign store_done  = (state_q == ST_STORE) && cnt_zero;
  assign recall_done = (state_q == ST_RECALL) && cnt_zero && vcc_ok;

  always_comb begin
    state_nx = state_q;
    ld       = 1'b0;
    ld_val   = '0;
    unique case (state_q)
      ST_OFF: begin
        if (vcc_ok) begin
          state_nx = ST_RECALL;
          ld       = 1'b1;
          ld_val   = TW'(RECALL_CYC - 1);
        end
      end
      ST_RECALL: begin
        if (!vcc_ok)      state_nx = ST_OFF;
        else if (cnt_zero) state_nx = ST_IDLE;
      end
      ST_IDLE: begin
        if (!vcc_ok || store_req) begin
          if (dirty) begin
            state_nx = ST_GRACE;
            ld       = 1'b1;
            ld_val   = TW'(GRACE_CYC - 1);
          end else if (!vcc_ok) begin
            state_nx = ST_OFF;
          end
        end
      end
      ST_GRACE: begin
        if (cnt_zero) begin
          state_nx = ST_STORE;
          ld       = 1'b1;
          ld_val   = TW'(STORE_CYC - 1);
        end
      end
      ST_STORE: begin
        if (cnt_zero) state_nx = (fell_q || !vcc_ok) ? ST_OFF : ST_IDLE;
      end
      default: state_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      fell_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      if (ld)             cnt_q <= ld_val;
      else if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
      if (state_nx == ST_OFF || state_nx == ST_IDLE || state_nx == ST_RECALL)
        fell_q <= 1'b0;
      else if (!vcc_ok)
        fell_q <= 1'b1;
    end
  end
endmodule

// File: rtl/nvs_host_gate.sv
module nvs_host_gate
  import nvs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  nvs_state_t state_q,
  input  logic       vcc_ok,
  input  logic       host_rd,
  input  logic       host_wr,
  output logic       wr_accept,
  output logic       sram_rd_q,
  output logic       sram_wr_q
);
  logic open_now;

  assign open_now  = ((state_q == ST_IDLE) && vcc_ok) || (state_q == ST_GRACE);
  assign wr_accept = open_now && host_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_rd_q <= 1'b0;
      sram_wr_q <= 1'b0;
    end else begin
      sram_rd_q <= open_now && host_rd;
      sram_wr_q <= wr_accept;
    end
  end
endmodule

// File: rtl/nvs_dirty.sv
module nvs_dirty (
  input  logic clk,
  input  logic rst,
  input  logic wr_accept,
  input  logic store_done,
  input  logic recall_done,
  output logic dirty_q
);
  always_ff @(posedge clk) begin
    if (rst)                            dirty_q <= 1'b0;
    else if (store_done || recall_done) dirty_q <= 1'b0;
    else if (wr_accept)                 dirty_q <= 1'b1;
  end
endmodule

// File: rtl/nvs_handshake.sv
module nvs_handshake #(
  parameter int HIGH_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_cur,
  input  logic busy_nx,
  input  logic vcc_live,
  output logic drive_lo_q,
  output logic drive_hi_q
);
  localparam int HW = $clog2(HIGH_CYC + 1);

  logic [HW-1:0] left_q;
  logic [HW-1:0] left_nx;

  always_comb begin
    if (busy_nx)                left_nx = '0;
    else if (busy_cur)          left_nx = HW'(HIGH_CYC);
    else if (left_q != '0)      left_nx = left_q - 1'b1;
    else                        left_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q     <= '0;
      drive_lo_q <= 1'b0;
      drive_hi_q <= 1'b0;
    end else begin
      left_q     <= left_nx;
      drive_lo_q <= vcc_live && busy_nx;
      drive_hi_q <= vcc_live && (left_nx != '0);
    end
  end
endmodule

// File: rtl/nvsram_cycle_ctrl.sv
module nvsram_cycle_ctrl
  import nvs_pkg::*;
#(
  parameter int RECALL_CYC = 40,
  parameter int STORE_CYC  = 24,
  parameter int GRACE_CYC  = 3,
  parameter int HIGH_CYC   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_ok,
  input  logic vcc_live,
  input  logic pin_store_n,
  input  logic host_rd,
  input  logic host_wr,
  output logic sram_rd,
  output logic sram_wr,
  output logic busy,
  output logic rw_block,
  output logic store_go,
  output logic recall_go,
  output logic hs_drive_lo,
  output logic hs_drive_hi
);
  nvs_state_t state_q, state_nx;
  logic store_done, recall_done, dirty_q, wr_accept;
  logic busy_nx, block_nx;

  nvs_fsm #(.RECALL_CYC(RECALL_CYC), .STORE_CYC(STORE_CYC), .GRACE_CYC(GRACE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .store_req(!pin_store_n), .dirty(dirty_q),
    .state_q(state_q), .state_nx(state_nx), .store_done(store_done), .recall_done(recall_done)
  );

  nvs_host_gate u_gate (
    .clk(clk), .rst(rst), .state_q(state_q), .vcc_ok(vcc_ok),
    .host_rd(host_rd), .host_wr(host_wr), .wr_accept(wr_accept),
    .sram_rd_q(sram_rd), .sram_wr_q(sram_wr)
  );

  nvs_dirty u_dirty (
    .clk(clk), .rst(rst), .wr_accept(wr_accept), .store_done(store_done),
    .recall_done(recall_done), .dirty_q(dirty_q)
  );

  assign busy_nx  = (state_nx == ST_RECALL) || (state_nx == ST_GRACE) || (state_nx == ST_STORE);
  assign block_nx = (state_nx == ST_OFF) || (state_nx == ST_RECALL) || (state_nx == ST_STORE);

  nvs_handshake #(.HIGH_CYC(HIGH_CYC)) u_hs (
    .clk(clk), .rst(rst), .busy_cur(busy), .busy_nx(busy_nx), .vcc_live(vcc_live),
    .drive_lo_q(hs_drive_lo), .drive_hi_q(hs_drive_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rw_block  <= 1'b1;
      store_go  <= 1'b0;
      recall_go <= 1'b0;
    end else begin
      busy      <= busy_nx;
      rw_block  <= block_nx;
      store_go  <= (state_nx == ST_STORE) && (state_q != ST_STORE);
      recall_go <= (state_nx == ST_RECALL) && (state_q != ST_RECALL);
    end
  end
endmodule

// File: rtl/nvsram_cycle_ctrl_chk.sv
module nvsram_cycle_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic vcc_live,
  input logic sram_rd,
  input logic sram_wr,
  input logic busy,
  input logic rw_block,
  input logic store_go,
  input logic recall_go,
  input logic hs_drive_lo,
  input logic hs_drive_hi
);
  p_recall_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    recall_go |=> !recall_go);
  p_recall_from_off_r1: assert property (@(posedge clk) disable iff (rst)
    recall_go |-> ($past(rw_block) && !$past(busy)));
  p_store_after_grace_r2: assert property (@(posedge clk) disable iff (rst)
    store_go |-> ($past(busy) && !$past(rw_block)));
  p_wr_only_when_open_r5: assert property (@(posedge clk) disable iff (rst)
    sram_wr |-> !$past(rw_block));
  p_rd_only_when_open_r5: assert property (@(posedge clk) disable iff (rst)
    sram_rd |-> !$past(rw_block));
  p_enables_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(hs_drive_lo && hs_drive_hi));
  p_lo_needs_busy_r6: assert property (@(posedge clk) disable iff (rst)
    hs_drive_lo |-> busy);
  p_released_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(vcc_live) |-> (!hs_drive_lo && !hs_drive_hi));
  p_one_start_r12: assert property (@(posedge clk) disable iff (rst)
    !(store_go && recall_go));
endmodule

bind nvsram_cycle_ctrl nvsram_cycle_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .vcc_live(vcc_live), .sram_rd(sram_rd), .sram_wr(sram_wr),
  .busy(busy), .rw_block(rw_block), .store_go(store_go), .recall_go(recall_go),
  .hs_drive_lo(hs_drive_lo), .hs_drive_hi(hs_drive_hi)
);

// File: tb/tb_nvsram_cycle_ctrl.sv
module tb_nvsram_cycle_ctrl;
  localparam int RC = 40, SC = 24, GC = 3, HC = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic vcc_ok = 1'b0, vcc_live = 1'b1, pin_store_n = 1'b1, host_rd = 1'b0, host_wr = 1'b0;
  logic sram_rd, sram_wr, busy, rw_block, store_go, recall_go, hs_drive_lo, hs_drive_hi;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nvsram_cycle_ctrl #(.RECALL_CYC(RC), .STORE_CYC(SC), .GRACE_CYC(GC), .HIGH_CYC(HC)) dut (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .vcc_live(vcc_live), .pin_store_n(pin_store_n),
    .host_rd(host_rd), .host_wr(host_wr), .sram_rd(sram_rd), .sram_wr(sram_wr),
    .busy(busy), .rw_block(rw_block), .store_go(store_go), .recall_go(recall_go),
    .hs_drive_lo(hs_drive_lo), .hs_drive_hi(hs_drive_hi)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "reset busy", busy, 1'b0);
    chk("R1", "reset rw_block", rw_block, 1'b1);
    chk("R6", "reset drive_lo", hs_drive_lo, 1'b0);
    chk("R6", "reset drive_hi", hs_drive_hi, 1'b0);
    chk("R3", "reset store_go", store_go, 1'b0);
  endtask

  // full recall from the powered-down state; tag names the requirement driving it
  task automatic t_powerup(input string tag);
    vcc_ok = 1'b1;
    step(1);
    chk(tag, "recall_go", recall_go, 1'b1);
    chk(tag, "busy at start", busy, 1'b1);
    chk("R6", "drive_lo in recall", hs_drive_lo, 1'b1);
    host_rd = 1'b1;
    step(1);
    chk("R5", "read dropped in recall", sram_rd, 1'b0);
    chk(tag, "recall_go single", recall_go, 1'b0);
    host_rd = 1'b0;
    step(RC - 2);
    chk(tag, "busy last recall cycle", busy, 1'b1);
    chk(tag, "rw_block last recall cycle", rw_block, 1'b1);
    step(1);
    chk(tag, "busy after recall", busy, 1'b0);
    chk(tag, "rw_block after recall", rw_block, 1'b0);
    chk("R6", "drive_hi after busy", hs_drive_hi, 1'b1);
    chk("R6", "drive_lo after busy", hs_drive_lo, 1'b0);
    step(HC - 1);
    chk("R6", "drive_hi last cycle", hs_drive_hi, 1'b1);
    step(1);
    chk("R6", "drive_hi released", hs_drive_hi, 1'b0);
  endtask

  task automatic t_idle_access();
    host_rd = 1'b1;
    step(1);
    chk("R5", "read passes in idle", sram_rd, 1'b1);
    host_rd = 1'b0;
    step(1);
    chk("R5", "read ends", sram_rd, 1'b0);
  endtask

  task automatic t_clean_request(input string tag);
    bit seen = 1'b0;
    pin_store_n = 1'b0;
    step(1);
    pin_store_n = 1'b1;
    for (int i = 0; i < GC + 3; i++) begin
      if (busy || store_go) seen = 1'b1;
      step(1);
    end
    chk(tag, "clean request starts nothing", seen, 1'b0);
  endtask

  task automatic t_write_once();
    host_wr = 1'b1;
    step(1);
    chk("R5", "write passes in idle", sram_wr, 1'b1);
    host_wr = 1'b0;
    step(1);
  endtask

  task automatic t_hw_store();
    pin_store_n = 1'b0;
    step(1);
    pin_store_n = 1'b1;
    chk("R7", "busy on request", busy, 1'b1);
    chk("R7", "no block in grace", rw_block, 1'b0);
    host_wr = 1'b1;
    step(1);
    chk("R4", "write in grace", sram_wr, 1'b1);
    host_wr = 1'b0;
    step(GC - 1);
    chk("R7", "store_go after grace", store_go, 1'b1);
    chk("R7", "block in store", rw_block, 1'b1);
    host_wr = 1'b1;
    step(1);
    chk("R5", "write dropped in store", sram_wr, 1'b0);
    host_wr = 1'b0;
    pin_store_n = 1'b0;
    step(1);
    pin_store_n = 1'b1;
    step(GC + SC - GC - 3);
    chk("R12", "busy last store cycle", busy, 1'b1);
    step(1);
    chk("R12", "busy ends on time", busy, 1'b0);
    chk("R7", "back to idle", rw_block, 1'b0);
    step(GC + 3);
    chk("R12", "no store after request in store", busy, 1'b0);
  endtask

  task automatic t_clean_drop();
    bit seen = 1'b0;
    vcc_ok = 1'b0;
    step(1);
    chk("R3", "blocked when clean drop", rw_block, 1'b1);
    for (int i = 0; i < GC + 3; i++) begin
      if (busy || store_go) seen = 1'b1;
      step(1);
    end
    chk("R3", "no store on clean drop", seen, 1'b0);
    host_wr = 1'b1;
    step(1);
    chk("R5", "write dropped when supply low", sram_wr, 1'b0);
    host_wr = 1'b0;
  endtask

  task automatic t_auto_store();
    vcc_ok = 1'b0;
    step(1);
    chk("R2", "busy on drop", busy, 1'b1);
    host_wr = 1'b1;
    step(1);
    chk("R4", "write in grace after drop", sram_wr, 1'b1);
    host_wr = 1'b0;
    step(GC - 1);
    chk("R2", "store_go", store_go, 1'b1);
    step(SC - 1);
    chk("R2", "busy last cycle", busy, 1'b1);
    step(1);
    chk("R2", "busy done", busy, 1'b0);
    chk("R2", "stays blocked", rw_block, 1'b1);
    step(3);
  endtask

  task automatic t_abort();
    bit seen = 1'b0;
    vcc_ok = 1'b1;
    step(10);
    vcc_ok = 1'b0;
    step(1);
    chk("R9", "busy drops on abort", busy, 1'b0);
    chk("R9", "blocked on abort", rw_block, 1'b1);
    for (int i = 0; i < GC + SC; i++) begin
      if (store_go || busy) seen = 1'b1;
      step(1);
    end
    chk("R9", "no store after abort", seen, 1'b0);
  endtask

  task automatic t_tristate();
    vcc_live = 1'b0;
    vcc_ok = 1'b1;
    step(2);
    chk("R10", "busy in recall", busy, 1'b1);
    chk("R10", "drive_lo released", hs_drive_lo, 1'b0);
    vcc_live = 1'b1;
    step(1);
    chk("R10", "drive_lo back", hs_drive_lo, 1'b1);
    step(RC - 2);
    vcc_live = 1'b0;
    step(1);
    chk("R10", "busy ended", busy, 1'b0);
    chk("R10", "drive_hi released", hs_drive_hi, 1'b0);
    vcc_live = 1'b1;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_powerup("R1");
    t_idle_access();
    t_clean_request("R3");
    t_write_once();
    t_hw_store();
    t_clean_request("R11");
    t_clean_drop();
    t_powerup("R1");
    t_write_once();
    t_auto_store();
    t_powerup("R8");
    t_clean_request("R11");
    vcc_ok = 1'b0;
    step(3);
    t_abort();
    t_tristate();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule